// File: doc/BRIEF.md
# Three-Phase Gate Signal Conditioner

This block sits between a three-phase PWM timer and the six gate-drive pins of an inverter. Each of the three phases has one high-side and one low-side raw signal. The block conditions these six signals in a fixed chain of stages:

1. Switched-reluctance forcing.
2. Per-phase swapping of the high and low signals.
3. Per-pin output enables.
4. Gating with a high-frequency chopping square wave, for pulse-transformer drive.
5. A global polarity choice.

The final six levels are registered, so that no combinational glitch reaches a pin.

The configuration inputs are the enable mask, the swap bits, the chop divider and the two chop enables. They are sampled into shadow registers only on the cycle where `period_start` is high. Software may change them at any time, and the new values take effect at the next PWM period boundary. The reluctance pin and the polarity pin act directly on every cycle.

None of the inputs is a stream. The raw signals and the configuration are sampled level signals, so there is no valid/ready handshake and no back-pressure: every input is consumed on every clock.

Top module: `pgc_gate_conditioner`

## Requirements
- R1: While `reluct_n_i` is low, all three low-side signals entering the swap stage are forced to 1, whatever `raw_lo_i` is. The high-side raw signals pass unchanged.
- R2: When bit i of the latched swap mask is set (bit 0 = phase A, 1 = B, 2 = C), phase i's high pin carries that phase's low signal and its low pin carries that phase's high signal.
- R3: Latched enable bits [2:0] gate the high pins of phases A, B and C, and bits [5:3] gate the low pins of phases A, B and C. A pin whose bit is 0 is held at its inactive level: 0 when `pol_i` = 1, and 1 when `pol_i` = 0.
- R4: The chop wave goes to 1 on the clock edge where `period_start` is high. It then holds each level for 4×(D+1) clocks before toggling, where D is the latched 8-bit divider.
- R5: When the latched high-side chop enable is set, the three high pins are ANDed with the chop wave. The latched low-side chop enable does the same for the three low pins, independently of the high side.
- R6: With `pol_i` = 1 the pins are active-high. With `pol_i` = 0 all six pins are the inverse of the active-high result.
- R7: Changes on `seg_en_i`, `xover_i`, `chop_div_i`, `chop_hi_en_i` and `chop_lo_en_i` have no effect on the pins until a cycle with `period_start` high.
- R8: The pins are registered, so an input change shows on the pins after one clock edge. A synchronous reset (`rst_n` low) drives all pins to the inactive level set by `pol_i`, and clears the shadow configuration to: all pins disabled, no swap, no chopping, D = 0.
- R9: The stages apply in a fixed order: reluctance forcing, then swap, then enable, then chop, then polarity. Enable and chop act on pin position, after the swap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| period_start | input | 1 | One-cycle strobe at each PWM period start |
| raw_hi_i | input | 3 | Raw high-side signals, bits C,B,A |
| raw_lo_i | input | 3 | Raw low-side signals, bits C,B,A |
| seg_en_i | input | 6 | Pin enables: [5:3] low C..A, [2:0] high C..A |
| xover_i | input | 3 | Per-phase swap bits, C,B,A |
| chop_div_i | input | 8 | Chop divider D |
| chop_hi_en_i | input | 1 | Chop enable, high side |
| chop_lo_en_i | input | 1 | Chop enable, low side |
| reluct_n_i | input | 1 | Low selects switched-reluctance mode |
| pol_i | input | 1 | 1 = active-high pins, 0 = active-low pins |
| gate_hi_o | output | 3 | High-side gate pins, C,B,A |
| gate_lo_o | output | 3 | Low-side gate pins, C,B,A |

## Verification
Chopping and the period-start reload can land on the same edge. The strobe restarts the chop wave while, on that same edge, a new divider and new chop enables are latched.

The bench sets a divider and a side enable together with the strobe. It then counts output cycles from that edge and expects exactly 4×(D+1) chopped-high cycles before the first chopped-low cycle. It does this for the high side with D = 0 and for the low side with D = 1, while the other side stays unchopped.

Swap and reluctance forcing also meet in one cycle. A vector with both active shows whether forcing happens before the swap.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int NPAIR  = 3;
  localparam int NPIN   = 2 * NPAIR;
  localparam int DIV_W  = 8;

  typedef struct packed {
    logic [NPIN-1:0]  seg_en;
    logic [NPAIR-1:0] xover;
    logic [DIV_W-1:0] chop_div;
    logic             chop_hi_en;
    logic             chop_lo_en;
  } pgc_cfg_t;
endpackage

// File: rtl/pgc_shadow_regs.sv
module pgc_shadow_regs
  import pgc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  pgc_cfg_t cfg_i,
  output pgc_cfg_t cfg_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cfg_o <= '0;
    else if (load) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/pgc_chop_gen.sv
module pgc_chop_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             chop_o
);
  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // terminal count of one half period: 4*(div+1)-1
  assign last = {div, 2'b11};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      chop_o <= 1'b1;
    end else if (restart) begin
      cnt    <= '0;
      chop_o <= 1'b1;
    end else if (cnt == last) begin
      cnt    <= '0;
      chop_o <= ~chop_o;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pgc_steer.sv
module pgc_steer
  import pgc_pkg::*;
(
  input  logic [NPAIR-1:0] raw_hi,
  input  logic [NPAIR-1:0] raw_lo,
  input  logic             reluct_n,
  input  logic             pol,
  input  logic             chop,
  input  pgc_cfg_t         cfg,
  output logic [NPAIR-1:0] hi_o,
  output logic [NPAIR-1:0] lo_o
);
  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic lo_f, h_x, l_x, h_m, l_m, h_c, l_c;
    always_comb begin
      lo_f = reluct_n ? raw_lo[i] : 1'b1;
      h_x  = cfg.xover[i] ? lo_f : raw_hi[i];
      l_x  = cfg.xover[i] ? raw_hi[i] : lo_f;
      h_m  = h_x & cfg.seg_en[i];
      l_m  = l_x & cfg.seg_en[NPAIR+i];
      h_c  = cfg.chop_hi_en ? (h_m & chop) : h_m;
      l_c  = cfg.chop_lo_en ? (l_m & chop) : l_m;
      hi_o[i] = pol ? h_c : ~h_c;
      lo_o[i] = pol ? l_c : ~l_c;
    end
  end
endmodule

// File: rtl/pgc_gate_conditioner.sv
module pgc_gate_conditioner
  import pgc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_start,
  input  logic [NPAIR-1:0] raw_hi_i,
  input  logic [NPAIR-1:0] raw_lo_i,
  input  logic [NPIN-1:0]  seg_en_i,
  input  logic [NPAIR-1:0] xover_i,
  input  logic [DIV_W-1:0] chop_div_i,
  input  logic             chop_hi_en_i,
  input  logic             chop_lo_en_i,
  input  logic             reluct_n_i,
  input  logic             pol_i,
  output logic [NPAIR-1:0] gate_hi_o,
  output logic [NPAIR-1:0] gate_lo_o
);
  pgc_cfg_t         cfg_d, cfg_q;
  logic             chop;
  logic [NPAIR-1:0] hi_n, lo_n;

  assign cfg_d = '{seg_en: seg_en_i, xover: xover_i, chop_div: chop_div_i,
                   chop_hi_en: chop_hi_en_i, chop_lo_en: chop_lo_en_i};

  pgc_shadow_regs u_shadow (
    .clk(clk), .rst_n(rst_n), .load(period_start), .cfg_i(cfg_d), .cfg_o(cfg_q)
  );

  pgc_chop_gen #(.DIV_W(DIV_W)) u_chop (
    .clk(clk), .rst_n(rst_n), .restart(period_start),
    .div(cfg_q.chop_div), .chop_o(chop)
  );

  pgc_steer u_steer (
    .raw_hi(raw_hi_i), .raw_lo(raw_lo_i), .reluct_n(reluct_n_i), .pol(pol_i),
    .chop(chop), .cfg(cfg_q), .hi_o(hi_n), .lo_o(lo_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_hi_o <= {NPAIR{~pol_i}};
      gate_lo_o <= {NPAIR{~pol_i}};
    end else begin
      gate_hi_o <= hi_n;
      gate_lo_o <= lo_n;
    end
  end
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker
  import pgc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             period_start,
  input logic             reluct_n_i,
  input logic             pol_i,
  input logic             chop,
  input pgc_cfg_t         cfg_q,
  input logic [NPAIR-1:0] gate_hi_o,
  input logic [NPAIR-1:0] gate_lo_o
);
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(period_start) |-> cfg_q == $past(cfg_q)); // R7

  AST_CHOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(period_start) |-> chop); // R4

  AST_DISABLED_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((({gate_lo_o, gate_hi_o}) ^ {NPIN{~$past(pol_i)}}) & ~$past(cfg_q.seg_en)) == '0); // R3

  AST_HI_CHOPPED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_q.chop_hi_en && !chop) |-> gate_hi_o == {NPAIR{~$past(pol_i)}}); // R5

  AST_RELUCT_LO_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!reluct_n_i && cfg_q.seg_en[NPIN-1:NPAIR] == '1 && cfg_q.xover == '0 && !cfg_q.chop_lo_en)
    |-> gate_lo_o == {NPAIR{$past(pol_i)}}); // R1
endmodule

bind pgc_gate_conditioner pgc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .period_start(period_start), .reluct_n_i(reluct_n_i),
  .pol_i(pol_i), .chop(chop), .cfg_q(cfg_q), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
);

// File: tb/tb_pgc_gate_conditioner.sv
`timescale 1ns/1ps
module tb_pgc_gate_conditioner;
  logic clk = 0, rst_n = 0, period_start = 0;
  logic [2:0] raw_hi_i = 0, raw_lo_i = 0, xover_i = 0;
  logic [5:0] seg_en_i = 0;
  logic [7:0] chop_div_i = 0;
  logic chop_hi_en_i = 0, chop_lo_en_i = 0, reluct_n_i = 1, pol_i = 1;
  logic [2:0] gate_hi_o, gate_lo_o;
  int errors = 0, checks = 0, cycles = 0;

  always #4 clk = ~clk;

  pgc_gate_conditioner dut (.*);

  // {raw_hi, raw_lo, seg_en, xover, reluct_n, pol, exp_hi, exp_lo}
  localparam int NV = 9;
  localparam logic [22:0] VEC [NV] = '{
    23'b101_010_111111_000_1_1_101_010, // R6 active-high
    23'b101_010_111111_000_1_0_010_101, // R6 active-low
    23'b101_010_111111_001_1_1_100_011, // R2 swap A
    23'b101_010_111111_111_1_1_010_101, // R2 swap all
    23'b101_000_111111_000_0_1_101_111, // R1 reluctance
    23'b101_000_111111_010_0_1_111_101, // R9 force before swap
    23'b111_111_000101_000_1_1_101_000, // R3 partial enable
    23'b111_111_000101_000_1_0_010_111, // R3 inactive active-low
    23'b000_001_111110_001_1_1_000_000  // R9 enable after swap
  };

  function automatic string vtag(int i);
    case (i)
      0, 1: return "R6";
      2, 3: return "R2";
      4: return "R1";
      5, 8: return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string tag, logic [2:0] got_h, logic [2:0] got_l,
                       logic [2:0] exp_h, logic [2:0] exp_l);
    checks++;
    if (got_h !== exp_h || got_l !== exp_l) begin
      errors++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, got_h, got_l, exp_h, exp_l);
    end
  endtask

  // called at a negedge; latches config on the next posedge
  task automatic strobe_cfg(logic [5:0] seg, logic [2:0] xo, logic [7:0] dv,
                            logic ch, logic cl);
    seg_en_i = seg; xover_i = xo; chop_div_i = dv;
    chop_hi_en_i = ch; chop_lo_en_i = cl; period_start = 1;
    @(negedge clk);
    period_start = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected under 20000", cycles);
      finish_run();
    end
  end

  initial begin
    // R8 reset state follows polarity
    pol_i = 1;
    repeat (2) @(negedge clk);
    check("R8 reset active-high", gate_hi_o, gate_lo_o, 3'b000, 3'b000);
    pol_i = 0;
    @(negedge clk);
    check("R8 reset active-low", gate_hi_o, gate_lo_o, 3'b111, 3'b111);
    pol_i = 1; rst_n = 1;
    @(negedge clk);
    raw_hi_i = 3'b111; raw_lo_i = 3'b111;
    @(negedge clk);
    check("R8 shadow cleared after reset", gate_hi_o, gate_lo_o, 3'b000, 3'b000);

    for (int i = 0; i < NV; i++) begin
      raw_hi_i = VEC[i][22:20]; raw_lo_i = VEC[i][19:17];
      reluct_n_i = VEC[i][7]; pol_i = VEC[i][6];
      strobe_cfg(VEC[i][16:11], VEC[i][10:8], 8'd0, 1'b0, 1'b0);
      @(negedge clk);
      check(vtag(i), gate_hi_o, gate_lo_o, VEC[i][5:3], VEC[i][2:0]);
    end

    // R7: config changes without a strobe are ignored
    raw_hi_i = 3'b101; raw_lo_i = 3'b010; reluct_n_i = 1; pol_i = 1;
    strobe_cfg(6'b111111, 3'b000, 8'd0, 1'b0, 1'b0);
    seg_en_i = 6'b000000; xover_i = 3'b111; chop_hi_en_i = 1; chop_lo_en_i = 1;
    repeat (3) @(negedge clk);
    check("R7 held without strobe", gate_hi_o, gate_lo_o, 3'b101, 3'b010);
    period_start = 1;
    @(negedge clk);
    period_start = 0;
    @(negedge clk);
    check("R7 applied at strobe", gate_hi_o, gate_lo_o, 3'b000, 3'b000);

    // R8: one-edge latency
    strobe_cfg(6'b111111, 3'b000, 8'd0, 1'b0, 1'b0);
    raw_hi_i = 3'b000; raw_lo_i = 3'b000;
    @(negedge clk);
    raw_hi_i = 3'b111;
    #1;
    check("R8 no change before edge", gate_hi_o, gate_lo_o, 3'b000, 3'b000);
    @(negedge clk);
    check("R8 change after one edge", gate_hi_o, gate_lo_o, 3'b111, 3'b000);

    // R4/R5: high-side chop, D=0 -> 4 cycles high, 4 low
    raw_hi_i = 3'b111; raw_lo_i = 3'b111;
    strobe_cfg(6'b111111, 3'b000, 8'd0, 1'b1, 1'b0);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check((k <= 4 || k >= 9) ? "R4 hi chop high phase" : "R5 hi chop low phase",
            gate_hi_o, gate_lo_o, (k <= 4 || k >= 9) ? 3'b111 : 3'b000, 3'b111);
    end

    // R4/R5: low-side chop only, D=1 -> 8 cycles high, 8 low, with restart
    strobe_cfg(6'b111111, 3'b000, 8'd1, 1'b0, 1'b1);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      check((k <= 8) ? "R4 lo chop high phase" : "R5 lo chop low phase",
            gate_hi_o, gate_lo_o, 3'b111, (k <= 8) ? 3'b111 : 3'b000);
    end

    // R5 with active-low pins: chopped-off pin shows inactive 1
    pol_i = 0;
    strobe_cfg(6'b111111, 3'b000, 8'd0, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    check("R5 chop with active-low", gate_hi_o, gate_lo_o, 3'b111, 3'b000);

    finish_run();
  end
endmodule